// File: doc/BRIEF.md
# Boot-Overlay Chip-Select Decoder

This block turns a 24-bit processor address and its read and write strobes into one-hot chip selects for a board's RAM, ROM, configuration-switch port and interrupt controller, plus one select per host-link register. Any access that falls in a reserved or unmapped region drives no select. Instead it raises a bus-error flag in the same cycle.

After reset the decoder starts in boot mode. In this mode the whole low memory window mirrors the ROM, so the processor's first fetch at address zero reads ROM code. That code branches into the ROM's normal high window. The first write cycle that follows, whatever its address, ends boot mode from the next clock onward, and the low window then selects RAM. Only a reset can bring boot mode back.

The reset input is asserted asynchronously and released through a synchronizer. For that reason, writes made while reset is asserted, or on either of the two clock edges after its release, leave the decoder in boot mode.

Top module: `bdec_top`

## Requirements
- R1: While in boot mode (from reset until the first counted write), any access in 0x000000–0x3FFFFF asserts `sel_rom` and not `sel_ram`.
- R2: A write strobe sampled on a clock edge outside reset ends boot mode from the following cycle; the write can target any address, including a non-memory one. Afterwards, accesses in 0x000000–0x3FFFFF assert `sel_ram`. The write cycle itself is still decoded in boot mode.
- R3: Boot mode is re-entered only through reset. A write held on the clock edge after `rst_n` rises, or on the edge after that, does not end boot mode.
- R4: Accesses in 0xF00000–0xF3FFFF assert `sel_rom` in both modes.
- R5: Only the exact address 0xF90000 asserts `sel_cfg`.
- R6: Accesses in 0xFFFE00–0xFFFE3F assert `sel_irq`.
- R7: Accesses in 0xFFFFF0–0xFFFFFF assert `sel_link[k]` with k = address bits [3:1]. An even k is the status register of channel k/2, and an odd k is that channel's data register.
- R8: Accesses in 0x400000–0xEFFFFF, 0xF40000–0xFFFDFF (other than 0xF90000) and 0xFFFE40–0xFFFFEF assert `bus_err` and no select.
- R9: With both strobes low, every select and `bus_err` is low.
- R10: During any access, exactly one of the selects and `bus_err` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 24 | Byte address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| sel_ram | output | 1 | RAM select |
| sel_rom | output | 1 | ROM select |
| sel_cfg | output | 1 | Configuration-switch port select |
| sel_irq | output | 1 | Interrupt-controller select |
| sel_link | output | 8 | Host-link register selects, index = addr[3:1] |
| bus_err | output | 1 | Unmapped-access flag |

## Verification
Reads are swept over both ends of every 64 KiB block of the address space, in boot mode and again in normal mode. Comparing the two sweeps shows whether the low window changes its target while nothing else moves. Every address is checked at the first and last byte of each mapped range and at the bytes just outside it, and all sixteen host-link byte addresses are checked one by one. These checks separate an off-by-one range end from a correct one, and a wrong status/data order from a correct one. Writes are aimed at low memory, at a peripheral address, and at the cycles just after reset release. This shows that the mode change follows any counted write but ignores writes that the synchronizer still holds in reset.

// File: rtl/bdec_pkg.sv
package bdec_pkg;

  typedef enum logic [2:0] {
    REG_NONE = 3'd0,
    REG_LOW  = 3'd1,
    REG_ROM  = 3'd2,
    REG_CFG  = 3'd3,
    REG_IRQ  = 3'd4,
    REG_LINK = 3'd5
  } region_e;

endpackage

// File: rtl/bdec_rst_sync.sv
module bdec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = chain_q[STAGES-1];
endmodule

// File: rtl/bdec_boot_flag.sv
module bdec_boot_flag (
  input  logic clk,
  input  logic rst_int_n,
  input  logic wr_en,
  output logic boot
);
  logic boot_q;
  logic boot_d;
  logic boot_en;

  // a write while booting is the only event that moves the flag
  always_comb begin
    boot_en = boot_q & wr_en;
    boot_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      boot_q <= 1'b1;
    end else if (boot_en) begin
      boot_q <= boot_d;
    end
  end

  assign boot = boot_q;
endmodule

// File: rtl/bdec_range.sv
module bdec_range #(
  parameter int             AW = 24,
  parameter logic [AW-1:0] LO = '0,
  parameter logic [AW-1:0] HI = '1
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  generate
    if (LO == '0 && HI == TOP) begin : g_all
      assign hit = 1'b1;
    end else if (LO == '0) begin : g_upper
      assign hit = (addr <= HI);
    end else if (HI == TOP) begin : g_lower
      assign hit = (addr >= LO);
    end else begin : g_both
      assign hit = (addr >= LO) && (addr <= HI);
    end
  endgenerate
endmodule

// File: rtl/bdec_classify.sv
module bdec_classify
  import bdec_pkg::*;
#(
  parameter int             AW        = 24,
  parameter logic [AW-1:0] LOW_HI    = 24'h3FFFFF,
  parameter logic [AW-1:0] ROM_LO    = 24'hF00000,
  parameter logic [AW-1:0] ROM_HI    = 24'hF3FFFF,
  parameter logic [AW-1:0] CFG_ADDR  = 24'hF90000,
  parameter logic [AW-1:0] IRQ_LO    = 24'hFFFE00,
  parameter logic [AW-1:0] IRQ_HI    = 24'hFFFE3F,
  parameter logic [AW-1:0] LINK_BASE = 24'hFFFFF0,
  parameter int             LINK_IW   = 3
) (
  input  logic [AW-1:0]      addr,
  output region_e            region,
  output logic [LINK_IW-1:0] link_idx
);
  // each link register is two bytes wide
  localparam logic [AW-1:0] LINK_HI = LINK_BASE + AW'((2 ** LINK_IW) * 2 - 1);

  logic hit_low, hit_rom, hit_irq, hit_link, hit_cfg;

  bdec_range #(.AW(AW), .LO('0),       .HI(LOW_HI))  u_low  (.addr(addr), .hit(hit_low));
  bdec_range #(.AW(AW), .LO(ROM_LO),    .HI(ROM_HI))  u_rom  (.addr(addr), .hit(hit_rom));
  bdec_range #(.AW(AW), .LO(IRQ_LO),    .HI(IRQ_HI))  u_irq  (.addr(addr), .hit(hit_irq));
  bdec_range #(.AW(AW), .LO(LINK_BASE), .HI(LINK_HI)) u_link (.addr(addr), .hit(hit_link));

  assign hit_cfg  = (addr == CFG_ADDR);
  assign link_idx = addr[LINK_IW:1];

  always_comb begin
    region = REG_NONE;
    if (hit_low)       region = REG_LOW;
    else if (hit_rom)  region = REG_ROM;
    else if (hit_cfg)  region = REG_CFG;
    else if (hit_irq)  region = REG_IRQ;
    else if (hit_link) region = REG_LINK;
  end
endmodule

// File: rtl/bdec_top.sv
module bdec_top
  import bdec_pkg::*;
#(
  parameter int             ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] LOW_HI    = 24'h3FFFFF,
  parameter logic [ADDR_W-1:0] ROM_LO    = 24'hF00000,
  parameter logic [ADDR_W-1:0] ROM_HI    = 24'hF3FFFF,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 24'hF90000,
  parameter logic [ADDR_W-1:0] IRQ_LO    = 24'hFFFE00,
  parameter logic [ADDR_W-1:0] IRQ_HI    = 24'hFFFE3F,
  parameter logic [ADDR_W-1:0] LINK_BASE = 24'hFFFFF0,
  parameter int             LINK_CH   = 4,
  parameter int             SYNC_STG  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           rd_en,
  input  logic                           wr_en,
  output logic                           sel_ram,
  output logic                           sel_rom,
  output logic                           sel_cfg,
  output logic                           sel_irq,
  output logic [2*LINK_CH-1:0]           sel_link,
  output logic                           bus_err
);
  localparam int LINK_REGS = 2 * LINK_CH;
  localparam int LINK_IW   = $clog2(LINK_REGS);

  logic               rst_int_n;
  logic               boot;
  logic               acc;
  region_e            region;
  logic [LINK_IW-1:0] link_idx;

  bdec_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n)
  );

  bdec_boot_flag u_boot (
    .clk(clk), .rst_int_n(rst_int_n), .wr_en(wr_en), .boot(boot)
  );

  bdec_classify #(
    .AW(ADDR_W), .LOW_HI(LOW_HI), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI),
    .CFG_ADDR(CFG_ADDR), .IRQ_LO(IRQ_LO), .IRQ_HI(IRQ_HI),
    .LINK_BASE(LINK_BASE), .LINK_IW(LINK_IW)
  ) u_cls (
    .addr(addr), .region(region), .link_idx(link_idx)
  );

  assign acc = rd_en | wr_en;

  always_comb begin
    sel_ram = 1'b0;
    sel_rom = 1'b0;
    sel_cfg = 1'b0;
    sel_irq = 1'b0;
    bus_err = 1'b0;
    if (acc) begin
      case (region)
        REG_LOW:  begin sel_rom = boot; sel_ram = ~boot; end
        REG_ROM:  sel_rom = 1'b1;
        REG_CFG:  sel_cfg = 1'b1;
        REG_IRQ:  sel_irq = 1'b1;
        REG_LINK: ;
        default:  bus_err = 1'b1;
      endcase
    end
  end

  for (genvar k = 0; k < LINK_REGS; k++) begin : g_link
    assign sel_link[k] = acc && (region == REG_LINK) && (link_idx == LINK_IW'(k));
  end
endmodule

// File: rtl/bdec_checker.sv
module bdec_checker #(
  parameter int             ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] LOW_HI   = 24'h3FFFFF,
  parameter logic [ADDR_W-1:0] ROM_LO   = 24'hF00000,
  parameter logic [ADDR_W-1:0] ROM_HI   = 24'hF3FFFF,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 24'hF90000,
  parameter logic [ADDR_W-1:0] IRQ_LO   = 24'hFFFE00,
  parameter logic [ADDR_W-1:0] IRQ_HI   = 24'hFFFE3F,
  parameter int             NLINK    = 8
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic              sel_ram,
  input logic              sel_rom,
  input logic              sel_cfg,
  input logic              sel_irq,
  input logic [NLINK-1:0]  sel_link,
  input logic              bus_err
);
  a_r10_one_output: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en || wr_en) |-> $countones({sel_ram, sel_rom, sel_cfg, sel_irq, sel_link, bus_err}) == 1);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(rd_en || wr_en) |-> ({sel_ram, sel_rom, sel_cfg, sel_irq, sel_link, bus_err} == '0));

  a_r2_write_ends_boot: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en |=> !(sel_rom && addr <= LOW_HI));

  a_r3_ram_persists: assert property (@(posedge clk) disable iff (!rst_int_n)
    sel_ram |=> !(sel_rom && addr <= LOW_HI));

  a_r4_rom_window: assert property (@(posedge clk) disable iff (!rst_int_n)
    sel_rom |-> ((addr >= ROM_LO && addr <= ROM_HI) || addr <= LOW_HI));

  a_r5_cfg_exact: assert property (@(posedge clk) disable iff (!rst_int_n)
    sel_cfg |-> addr == CFG_ADDR);

  a_r6_irq_window: assert property (@(posedge clk) disable iff (!rst_int_n)
    sel_irq |-> (addr >= IRQ_LO && addr <= IRQ_HI));

  a_r8_err_not_low: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_err |-> addr > LOW_HI);
endmodule

bind bdec_top bdec_checker #(
  .ADDR_W(ADDR_W), .LOW_HI(LOW_HI), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI),
  .CFG_ADDR(CFG_ADDR), .IRQ_LO(IRQ_LO), .IRQ_HI(IRQ_HI), .NLINK(2 * LINK_CH)
) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_cfg(sel_cfg), .sel_irq(sel_irq),
  .sel_link(sel_link), .bus_err(bus_err)
);

// File: tb/tb_bdec_top.sv
module tb_bdec_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] addr;
  logic        rd_en, wr_en;
  logic        sel_ram, sel_rom, sel_cfg, sel_irq, bus_err;
  logic [7:0]  sel_link;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bdec_top dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_cfg(sel_cfg), .sel_irq(sel_irq),
    .sel_link(sel_link), .bus_err(bus_err)
  );

  // packing: {ram, rom, cfg, irq, link[7:0], err}
  function automatic logic [12:0] model(input logic [23:0] a, input bit boot, input bit acc);
    logic [12:0] v = '0;
    if (!acc) return v;
    if (a <= 24'h3FFFFF)                        v[12:11] = boot ? 2'b01 : 2'b10;
    else if (a >= 24'hF00000 && a <= 24'hF3FFFF) v[11] = 1'b1;
    else if (a == 24'hF90000)                   v[10] = 1'b1;
    else if (a >= 24'hFFFE00 && a <= 24'hFFFE3F) v[9] = 1'b1;
    else if (a >= 24'hFFFFF0)                   v[1 + int'((a - 24'hFFFFF0) >> 1)] = 1'b1;
    else                                        v[0] = 1'b1;
    return v;
  endfunction

  function automatic string tag_of(input logic [23:0] a, input bit boot);
    if (a <= 24'h3FFFFF) return boot ? "R1" : "R2";
    if (a >= 24'hF00000 && a <= 24'hF3FFFF) return "R4";
    if (a == 24'hF90000) return "R5";
    if (a >= 24'hFFFE00 && a <= 24'hFFFE3F) return "R6";
    if (a >= 24'hFFFFF0) return "R7";
    return "R8";
  endfunction

  function automatic logic [12:0] outs();
    return {sel_ram, sel_rom, sel_cfg, sel_irq, sel_link, bus_err};
  endfunction

  task automatic chk(input string tag, input logic [12:0] got, input logic [12:0] exp, input logic [23:0] a);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%06h actual=%013b expected=%013b", tag, a, got, exp);
    end
    if ($countones(got) > 1) begin
      n_chk++; n_bad++;
      $display("FAIL R10 addr=%06h actual=%013b expected=one-hot", a, got);
    end
  endtask

  // drive at falling edge, sample two ns later, before the next rising edge
  task automatic cyc(input logic [23:0] a, input bit r, input bit w);
    @(negedge clk);
    addr = a; rd_en = r; wr_en = w;
    #2;
  endtask

  task automatic sweep(input bit boot);
    logic [23:0] edges [0:17];
    edges = '{24'h000000, 24'h3FFFFF, 24'h400000, 24'hEFFFFF, 24'hF00000, 24'hF3FFFF,
              24'hF40000, 24'hF8FFFF, 24'hF90000, 24'hF90001, 24'hFFFDFF, 24'hFFFE00,
              24'hFFFE3F, 24'hFFFE40, 24'hFFFFEF, 24'hFFFFF0, 24'hFFFFFF, 24'h7FFFFF};
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 2; j++) begin
        logic [23:0] a = {8'(i), (j == 0) ? 16'h0000 : 16'hFFFF};
        cyc(a, 1'b1, 1'b0);
        chk(tag_of(a, boot), outs(), model(a, boot, 1'b1), a);
      end
    end
    foreach (edges[k]) begin
      cyc(edges[k], 1'b1, 1'b0);
      chk(tag_of(edges[k], boot), outs(), model(edges[k], boot, 1'b1), edges[k]);
    end
    for (int k = 0; k < 16; k++) begin
      logic [23:0] a = 24'hFFFFF0 + 24'(k);
      cyc(a, 1'b1, 1'b0);
      chk("R7", outs(), model(a, boot, 1'b1), a);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; rd_en = 1'b0; wr_en = 1'b0;
    repeat (3) @(posedge clk);
    // reset state: booting, low window is ROM
    cyc(24'h000000, 1'b1, 1'b0);
    chk("R1", outs(), model(24'h000000, 1'b1, 1'b1), 24'h000000);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    cyc(24'h123456, 1'b0, 1'b0);
    chk("R9", outs(), 13'b0, 24'h123456);
    cyc(24'hFFFFF6, 1'b0, 1'b0);
    chk("R9", outs(), 13'b0, 24'hFFFFF6);

    sweep(1'b1);

    // R2: write to a peripheral ends boot; the write itself is decoded normally
    cyc(24'hFFFE00, 1'b0, 1'b1);
    chk("R2", outs(), model(24'hFFFE00, 1'b1, 1'b1), 24'hFFFE00);
    cyc(24'h000000, 1'b1, 1'b0);
    chk("R2", outs(), model(24'h000000, 1'b0, 1'b1), 24'h000000);

    sweep(1'b0);

    // R3: reset restores boot; writes on the first two edges after release are ignored
    @(negedge clk); rst_n = 1'b0; rd_en = 1'b1; addr = 24'h000000;
    #2 chk("R3", outs(), model(24'h000000, 1'b1, 1'b1), 24'h000000);
    @(negedge clk); rst_n = 1'b1; wr_en = 1'b1; rd_en = 1'b0; addr = 24'h000010;
    @(posedge clk); @(posedge clk);
    cyc(24'h000000, 1'b1, 1'b0);
    chk("R3", outs(), model(24'h000000, 1'b1, 1'b1), 24'h000000);

    // R2: a write into low memory while booting selects ROM, then RAM afterwards
    cyc(24'h3FFFFF, 1'b0, 1'b1);
    chk("R1", outs(), model(24'h3FFFFF, 1'b1, 1'b1), 24'h3FFFFF);
    cyc(24'h3FFFFF, 1'b0, 1'b1);
    chk("R2", outs(), model(24'h3FFFFF, 1'b0, 1'b1), 24'h3FFFFF);
    cyc(24'hF00000, 1'b1, 1'b0);
    chk("R4", outs(), model(24'hF00000, 1'b0, 1'b1), 24'hF00000);
    cyc(24'h000000, 1'b0, 1'b0);
    chk("R9", outs(), 13'b0, 24'h000000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule